// File: doc/BRIEF.md
# Ring-Counter Controller-Sequencer

This block is the control unit of a small accumulator computer. It steps through a fixed cycle of six timing states. The first three states fetch an instruction and the last three execute it. A one-hot ring counter holds the current state and moves one position on every falling clock edge. Because the state changes on the falling edge, the control word is stable half a cycle before the rising edge at which the datapath registers act on it.

On each state, the block combines the state with the 4-bit opcode held in the instruction register and produces a 12-bit control word. That word drives the bus drivers, the register loads, the program counter step and the subtract select. Execute states that an instruction does not need produce an all-zero word. The halt opcode freezes the ring until reset. The datapath registers are not part of this block.

Top module: `seq_controller`

## Requirements
- R1: While `rst` is high at a falling edge, `t_state` becomes 6'b000001 (T1). During reset `ctrl_word` is all zeros and `halt` is low. Reset is synchronous and sampled on the falling edge.
- R2: `t_state` is one-hot, with bit i meaning state T(i+1). Outside reset and halt it moves from bit i to bit i+1 on each falling clock edge, and from T6 back to T1.
- R3: `ctrl_word` bits, from bit 11 down to bit 0, mean: PC step, PC drives bus, MAR load, memory drives bus, IR load, IR address drives bus, accumulator load, accumulator drives bus, subtract select, ALU drives bus, B load, output load. All bits are active-high. The fetch words are 12'h600 in T1, 12'h800 in T2 and 12'h180 in T3, whatever the opcode.
- R4: For load opcode 4'b0000 the execute words are T4 12'h240, T5 12'h120 and T6 12'h000.
- R5: For add opcode 4'b0001 the execute words are T4 12'h240, T5 12'h102 and T6 12'h024.
- R6: For subtract opcode 4'b0010 the execute words are T4 12'h240, T5 12'h102 and T6 12'h02C. The subtract bit (bit 3) is high only in T6 of this opcode.
- R7: For output opcode 4'b1110 the execute words are T4 12'h011, T5 12'h000 and T6 12'h000.
- R8: For halt opcode 4'b1111, `halt` rises in T4 and `ctrl_word` is zero. The ring stays at T4 with `halt` high and the word at zero until reset, even if the opcode then changes.
- R9: Any other opcode gives a zero word in T4 to T6, leaves `halt` low and lets the ring advance normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the ring advances on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field from the instruction register |
| ctrl_word | output | 12 | Control word for the datapath |
| t_state | output | 6 | One-hot timing state, bit 0 = T1 |
| halt | output | 1 | High once the halt opcode reaches T4 |

## Verification
The bench drives junk opcodes during T1 to T3 and switches to the real opcode only before T4. A decoder that let the opcode leak into fetch would show a wrong fetch word. After a halt, the opcode is changed to load: a design that only compared against the live opcode would drop `halt` and resume the ring. Unlisted opcodes are run to catch a decoder that falls into a real instruction. Reset is released on a falling edge, so a ring that skipped or doubled T1 after reset would misalign every later word.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;

  localparam int OP_W  = 4;
  localparam int CW_W  = 12;
  localparam int NUM_T = 6;

  // timing state positions inside the one-hot ring
  localparam int T_ADDR  = 0;
  localparam int T_STEP  = 1;
  localparam int T_GRAB  = 2;
  localparam int T_EX0   = 3;
  localparam int T_EX1   = 4;
  localparam int T_EX2   = 5;

  // control word bit positions (the datapath decodes this order)
  localparam int CW_PC_STEP = 11;
  localparam int CW_PC_DRV  = 10;
  localparam int CW_ADDR_LD = 9;
  localparam int CW_MEM_DRV = 8;
  localparam int CW_INSN_LD = 7;
  localparam int CW_ARG_DRV = 6;
  localparam int CW_ACC_LD  = 5;
  localparam int CW_ACC_DRV = 4;
  localparam int CW_SUB     = 3;
  localparam int CW_ALU_DRV = 2;
  localparam int CW_OPB_LD  = 1;
  localparam int CW_PORT_LD = 0;

  typedef enum logic [3:0] {
    OP_LOAD = 4'b0000,
    OP_ADD  = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_SHOW = 4'b1110,
    OP_STOP = 4'b1111
  } op_e;

  typedef struct packed {
    logic load;
    logic add;
    logic sub;
    logic show;
    logic stop;
  } op_class_t;

endpackage

// File: rtl/seq_ring.sv
module seq_ring #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  output logic [N-1:0] ring
);

  localparam logic [N-1:0] RING_HOME = {{(N-1){1'b0}}, 1'b1};

  always_ff @(negedge clk) begin
    if (rst) begin
      ring <= RING_HOME;
    end else if (!hold) begin
      ring <= {ring[N-2:0], ring[N-1]};
    end
  end

endmodule

// File: rtl/seq_op_decode.sv
module seq_op_decode
  import seq_ctrl_pkg::*;
#(
  parameter int W = OP_W
) (
  input  logic [W-1:0] opcode,
  output op_class_t    cls
);

  always_comb begin
    cls      = '0;
    cls.load = (opcode == W'(OP_LOAD));
    cls.add  = (opcode == W'(OP_ADD));
    cls.sub  = (opcode == W'(OP_SUB));
    cls.show = (opcode == W'(OP_SHOW));
    cls.stop = (opcode == W'(OP_STOP));
  end

endmodule

// File: rtl/seq_cw_encode.sv
module seq_cw_encode
  import seq_ctrl_pkg::*;
#(
  parameter int NT = NUM_T,
  parameter int CW = CW_W
) (
  input  logic [NT-1:0] ring,
  input  op_class_t     cls,
  output logic [CW-1:0] cw
);

  logic arith;
  assign arith = cls.add | cls.sub;

  always_comb begin
    cw = '0;
    // fetch: opcode plays no part
    if (ring[T_ADDR]) begin
      cw[CW_PC_DRV]  = 1'b1;
      cw[CW_ADDR_LD] = 1'b1;
    end
    if (ring[T_STEP]) begin
      cw[CW_PC_STEP] = 1'b1;
    end
    if (ring[T_GRAB]) begin
      cw[CW_MEM_DRV] = 1'b1;
      cw[CW_INSN_LD] = 1'b1;
    end
    // execute
    if (ring[T_EX0]) begin
      if (cls.load | arith) begin
        cw[CW_ARG_DRV] = 1'b1;
        cw[CW_ADDR_LD] = 1'b1;
      end
      if (cls.show) begin
        cw[CW_ACC_DRV] = 1'b1;
        cw[CW_PORT_LD] = 1'b1;
      end
    end
    if (ring[T_EX1]) begin
      if (cls.load) begin
        cw[CW_MEM_DRV] = 1'b1;
        cw[CW_ACC_LD]  = 1'b1;
      end
      if (arith) begin
        cw[CW_MEM_DRV] = 1'b1;
        cw[CW_OPB_LD]  = 1'b1;
      end
    end
    if (ring[T_EX2]) begin
      if (arith) begin
        cw[CW_ALU_DRV] = 1'b1;
        cw[CW_ACC_LD]  = 1'b1;
        cw[CW_SUB]     = cls.sub;
      end
    end
  end

endmodule

// File: rtl/seq_controller.sv
module seq_controller
  import seq_ctrl_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int CWW = CW_W,
  parameter int NT  = NUM_T
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic [CWW-1:0] ctrl_word,
  output logic [NT-1:0]  t_state,
  output logic           halt
);

  op_class_t      cls;
  logic [CWW-1:0] raw_cw;
  logic           stop_now;
  logic           halted_q;

  seq_op_decode #(.W(OPW)) u_dec (
    .opcode (opcode),
    .cls    (cls)
  );

  seq_ring #(.N(NT)) u_ring (
    .clk  (clk),
    .rst  (rst),
    .hold (halt),
    .ring (t_state)
  );

  seq_cw_encode #(.NT(NT), .CW(CWW)) u_enc (
    .ring (t_state),
    .cls  (cls),
    .cw   (raw_cw)
  );

  assign stop_now = t_state[T_EX0] & cls.stop;

  // sticky stop: once taken, later opcode changes cannot release it
  always_ff @(negedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
    end else if (stop_now) begin
      halted_q <= 1'b1;
    end
  end

  assign halt      = ~rst & (halted_q | stop_now);
  assign ctrl_word = (rst | halt) ? '0 : raw_cw;

endmodule

// File: rtl/seq_controller_chk.sv
module seq_controller_chk #(
  parameter int OPW = 4,
  parameter int CWW = 12,
  parameter int NT  = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] opcode,
  input logic [CWW-1:0] ctrl_word,
  input logic [NT-1:0]  t_state,
  input logic           halt
);

  localparam logic [NT-1:0] HOME = {{(NT-1){1'b0}}, 1'b1};

  p_home_after_reset_r1: assert property (@(negedge clk)
    rst |=> (t_state == HOME));

  p_quiet_in_reset_r1: assert property (@(negedge clk)
    rst |-> (ctrl_word == '0 && !halt));

  p_onehot_r2: assert property (@(negedge clk) disable iff (rst)
    $countones(t_state) == 1);

  p_rotate_r2: assert property (@(negedge clk) disable iff (rst)
    !halt |=> (t_state == {$past(t_state[NT-2:0]), $past(t_state[NT-1])}));

  p_fetch_step_r3: assert property (@(negedge clk) disable iff (rst)
    t_state[1] |-> (ctrl_word == 12'h800));

  p_sub_late_r6: assert property (@(negedge clk) disable iff (rst)
    ctrl_word[3] |-> (t_state[5] && opcode == 4'b0010));

  p_halt_freeze_r8: assert property (@(negedge clk) disable iff (rst)
    halt |=> (halt && $stable(t_state)));

  p_halt_silent_r8: assert property (@(negedge clk) disable iff (rst)
    halt |-> (ctrl_word == '0 && t_state[3]));

endmodule

bind seq_controller seq_controller_chk #(.OPW(OPW), .CWW(CWW), .NT(NT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opcode    (opcode),
  .ctrl_word (ctrl_word),
  .t_state   (t_state),
  .halt      (halt)
);

// File: tb/test_seq_controller.sv
module test_seq_controller;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'b0000;
  logic [11:0] ctrl_word;
  logic [5:0]  t_state;
  logic        halt;

  typedef struct {
    int          t;
    logic [11:0] cw;
    logic        h;
    string       req;
  } exp_t;

  exp_t q[$];
  int n_pushed = 0;
  int n_popped = 0;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  seq_controller i_seq_controller (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .ctrl_word (ctrl_word),
    .t_state   (t_state),
    .halt      (halt)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [11:0] fetch_cw(int t);
    case (t)
      0: return 12'h600;
      1: return 12'h800;
      default: return 12'h180;
    endcase
  endfunction

  function automatic logic [11:0] exec_cw(logic [3:0] op, int t);
    case (op)
      4'b0000: return (t == 3) ? 12'h240 : (t == 4) ? 12'h120 : 12'h000;
      4'b0001: return (t == 3) ? 12'h240 : (t == 4) ? 12'h102 : 12'h024;
      4'b0010: return (t == 3) ? 12'h240 : (t == 4) ? 12'h102 : 12'h02C;
      4'b1110: return (t == 3) ? 12'h011 : 12'h000;
      default: return 12'h000;
    endcase
  endfunction

  function automatic string exec_req(logic [3:0] op);
    case (op)
      4'b0000: return "R4";
      4'b0001: return "R5";
      4'b0010: return "R6";
      4'b1110: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic push(int t, logic [11:0] cw, logic h, string req);
    exp_t e;
    e.t = t; e.cw = cw; e.h = h; e.req = req;
    q.push_back(e);
    n_pushed++;
  endtask

  task automatic wait_drain();
    wait (n_popped == n_pushed);
  endtask

  // monitor: samples between the rising edge and the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (t_state !== (6'b1 << e.t) || ctrl_word !== e.cw || halt !== e.h) begin
          n_fail++;
          $display("FAIL %s: state=%b cw=%h halt=%b expected state=%b cw=%h halt=%b",
                   e.req, t_state, ctrl_word, halt, 6'(6'b1 << e.t), e.cw, e.h);
        end
        n_popped++;
      end
    end
  end

  task automatic do_reset();
    wait_drain();
    rst = 1'b1;
    push(0, 12'h000, 1'b0, "R1");
    push(0, 12'h000, 1'b0, "R1");
    wait_drain();
    @(negedge clk);
    #1 rst = 1'b0;
  endtask

  // junk opcode during fetch checks R3 independence
  task automatic run_instr(logic [3:0] junk, logic [3:0] op);
    int base;
    wait_drain();
    base = n_pushed;
    opcode = junk;
    for (int t = 0; t < 3; t++) push(t, fetch_cw(t), 1'b0, "R2 R3");
    for (int t = 3; t < 6; t++) push(t, exec_cw(op, t), 1'b0, exec_req(op));
    wait (n_popped == base + 3);
    opcode = op;
  endtask

  task automatic run_halt(logic [3:0] junk);
    int base;
    wait_drain();
    base = n_pushed;
    opcode = junk;
    for (int t = 0; t < 3; t++) push(t, fetch_cw(t), 1'b0, "R3");
    for (int k = 0; k < 4; k++) push(3, 12'h000, 1'b1, "R8");
    wait (n_popped == base + 3);
    opcode = 4'b1111;
    wait (n_popped == base + 5);
    opcode = 4'b0000;  // must not release the halt
    for (int k = 0; k < 3; k++) push(3, 12'h000, 1'b1, "R8 opcode changed");
    wait_drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    do_reset();
    run_instr(4'b1111, 4'b0000);
    run_instr(4'b0010, 4'b0001);
    run_instr(4'b0000, 4'b0010);
    run_instr(4'b0001, 4'b1110);
    run_instr(4'b1110, 4'b0101);
    run_instr(4'b0010, 4'b1000);
    run_instr(4'b0101, 4'b0010);
    run_halt(4'b0001);
    do_reset();
    run_instr(4'b1111, 4'b0001);
    run_instr(4'b0000, 4'b1110);
    wait_drain();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule